// File: doc/BRIEF.md
# Serial Control and Diagnostic Front End for an Octal Low-Side Driver

This block is the serial port logic of an eight-channel low-side switch. A host reaches it over a four-wire serial bus made of a clock, a data input, a data output and an active-low select. The block keeps an eight-bit shift register. When select goes low, the shift register loads the sensed level of every output pin. While select stays low, the block shifts the host's new control bits in and shifts the diagnostic bits out. When select goes high, it hands the shifted word to the downstream output latch, with a one-cycle strobe.

The bus pins run in a system clock domain. Each pin passes through a synchronizer, and its edges are detected after synchronization. Because data passes straight through the register, several devices can be chained on one select line: each device passes bits on eight serial clocks late. The serial output is given as a data bit plus an output-enable, so the pad or a higher level can build the three-state buffer. An external active-low clear pin is synchronized in the same way as the bus pins. Like the system reset, it wipes the block.

Top module: `spi_diag_front`

## Requirements
- R1: While `rst` is high, or the synchronized `drv_rst_n` is low, the block clears the shift register, `par_out`, `load_strobe`, `so_data` and `so_oe`. A strobe is not issued for this clear.
- R2: On a detected falling edge of `cs_n`, shift-register bit k loads `sense[k]`. A 1 means output pin k is sensed high.
- R3: On each detected falling edge of `sclk` while selected, the register shifts toward bit 7 and takes the synchronized `si` into bit 0. The first bit received therefore ends in bit 7.
- R4: On each detected rising edge of `sclk` while selected, `so_data` takes register bit 7. The first rising edge after select shows `sense[7]`. The following edges show `sense[6]` down to `sense[0]`.
- R5: `so_oe` is 1 exactly while the synchronized `cs_n` is low. `so_data` returns to 0 when select rises.
- R6: While `cs_n` is high, `sclk` activity changes neither the register, `so_data`, `par_out` nor `load_strobe`.
- R7: On a detected rising edge of `cs_n`, `par_out` takes the shift-register contents and `load_strobe` is high for exactly one cycle. Apart from a clear, `par_out` changes at no other time.
- R8: Any number of bits may be shifted. Bit n sent on `si` reappears on `so_data` at rising edge n+8, and `par_out` keeps the last eight bits received.
- R9: An `sclk` edge detected in the same cycle as a `cs_n` edge is discarded.
- R10: Each pin passes through `SYNC_STAGES` flops. An output reacts at the clock edge `SYNC_STAGES`+1 after the pin change: with the default of 2, on the third edge and not the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock pin (asynchronous) |
| si | input | 1 | Serial data input pin (asynchronous) |
| cs_n | input | 1 | Active-low select pin (asynchronous) |
| drv_rst_n | input | 1 | Active-low external clear pin (asynchronous) |
| sense | input | CH | Digital sensed level of each output pin |
| so_data | output | 1 | Serial output data bit |
| so_oe | output | 1 | Serial output enable; pad is high-impedance when 0 |
| par_out | output | CH | Control word for the output latch |
| load_strobe | output | 1 | One-cycle pulse when `par_out` is updated from a transfer |

## Verification
The two functions that can meet in one cycle are a select edge and a serial clock edge. The bench provokes this by moving `cs_n` and `sclk` in the same step, so both cross the synchronizers together. For the falling select, the bench sets `sense[7]`=1 and checks that `so_data` stays 0, which shows that the rising serial clock was dropped. It then checks that the next rising edge shows `sense[6]`, and that exactly eight falling edges reach `par_out`. The bench also checks the synchronizer latency by sampling `par_out` two and three clocks after select rises.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

  // positions of the bus pins inside the synchronizer vector
  localparam int PIN_SCLK = 0;
  localparam int PIN_SI   = 1;
  localparam int PIN_CS   = 2;
  localparam int PIN_CLR  = 3;
  localparam int NPINS    = 4;

  // idle levels loaded into the synchronizers by reset
  localparam logic [NPINS-1:0] PIN_IDLE = 4'b1100;

  // decoded bus events for one system clock cycle
  typedef struct packed {
    logic cs_low;
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
    logic sclk_fall;
    logic si_lvl;
  } bus_evt_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar b = 0; b < N; b++) begin : g_pin
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= {(STAGES+1){IDLE[b]}};
      else     chain <= {chain[STAGES-1:0], raw[b]};
    end

    assign level[b] = chain[STAGES-1];
    assign rise[b]  = chain[STAGES-1] & ~chain[STAGES];
    assign fall[b]  = ~chain[STAGES-1] & chain[STAGES];
  end

endmodule

// File: rtl/spi_diag_shreg.sv
module spi_diag_shreg
  import spi_diag_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          wipe,
  input  bus_evt_t      ev,
  input  logic [CH-1:0] sense,
  output logic [CH-1:0] sr,
  output logic          so_bit
);

  always_ff @(posedge clk) begin
    if (wipe) begin
      sr     <= '0;
      so_bit <= 1'b0;
    end else if (ev.cs_fall) begin
      sr <= sense;                  // diagnostic capture, any sclk edge dropped
    end else if (ev.cs_rise) begin
      so_bit <= 1'b0;               // any sclk edge dropped
    end else if (ev.cs_low) begin
      if (ev.sclk_rise) so_bit <= sr[CH-1];
      if (ev.sclk_fall) sr     <= {sr[CH-2:0], ev.si_lvl};
    end
  end

endmodule

// File: rtl/spi_out_latch.sv
module spi_out_latch #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          wipe,
  input  logic          commit,
  input  logic [CH-1:0] sr,
  output logic [CH-1:0] par_out,
  output logic          load_strobe
);

  always_ff @(posedge clk) begin
    if (wipe) begin
      par_out     <= '0;
      load_strobe <= 1'b0;
    end else begin
      load_strobe <= commit;
      if (commit) par_out <= sr;
    end
  end

endmodule

// File: rtl/spi_diag_front.sv
module spi_diag_front
  import spi_diag_pkg::*;
#(
  parameter int CH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          si,
  input  logic          cs_n,
  input  logic          drv_rst_n,
  input  logic [CH-1:0] sense,
  output logic          so_data,
  output logic          so_oe,
  output logic [CH-1:0] par_out,
  output logic          load_strobe
);

  logic [NPINS-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic [CH-1:0]    sr;
  logic             wipe;
  bus_evt_t         ev;
  logic             unused_edges;

  assign pin_raw[PIN_SCLK] = sclk;
  assign pin_raw[PIN_SI]   = si;
  assign pin_raw[PIN_CS]   = cs_n;
  assign pin_raw[PIN_CLR]  = drv_rst_n;

  spi_pin_sync #(.N(NPINS), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw   (pin_raw),
    .level (pin_lvl),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  assign unused_edges = ^{pin_rise[PIN_SI], pin_fall[PIN_SI],
                          pin_rise[PIN_CLR], pin_fall[PIN_CLR]};

  assign wipe = rst | ~pin_lvl[PIN_CLR];

  always_comb begin
    ev.cs_low    = ~pin_lvl[PIN_CS];
    ev.cs_fall   = pin_fall[PIN_CS];
    ev.cs_rise   = pin_rise[PIN_CS];
    ev.sclk_rise = pin_rise[PIN_SCLK];
    ev.sclk_fall = pin_fall[PIN_SCLK];
    ev.si_lvl    = pin_lvl[PIN_SI];
  end

  spi_diag_shreg #(.CH(CH)) u_shreg (
    .clk    (clk),
    .wipe   (wipe),
    .ev     (ev),
    .sense  (sense),
    .sr     (sr),
    .so_bit (so_data)
  );

  spi_out_latch #(.CH(CH)) u_latch (
    .clk         (clk),
    .wipe        (wipe),
    .commit      (ev.cs_rise),
    .sr          (sr),
    .par_out     (par_out),
    .load_strobe (load_strobe)
  );

  always_ff @(posedge clk) begin
    if (wipe) so_oe <= 1'b0;
    else      so_oe <= ~pin_lvl[PIN_CS];
  end

endmodule

// File: rtl/spi_diag_front_chk.sv
module spi_diag_front_chk #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wipe,
  input logic          so_data,
  input logic          so_oe,
  input logic [CH-1:0] par_out,
  input logic          load_strobe
);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> !load_strobe);

  // R7
  par_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(par_out) |-> (load_strobe || $past(wipe)));

  // R1
  wipe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wipe) |-> (!so_oe && !load_strobe && par_out == '0 && !so_data));

  // R5
  strobe_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    load_strobe |-> !so_oe);

  // R5
  so_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(so_data) |-> ($past(so_oe) || $past(wipe)));

endmodule

bind spi_diag_front spi_diag_front_chk #(.CH(CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wipe        (wipe),
  .so_data     (so_data),
  .so_oe       (so_oe),
  .par_out     (par_out),
  .load_strobe (load_strobe)
);

// File: tb/spi_diag_front_test.sv
module spi_diag_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0, si = 1'b0, cs_n = 1'b1, drv_rst_n = 1'b1;
  logic [7:0] sense = 8'h00;
  logic       so_data, so_oe, load_strobe;
  logic [7:0] par_out;

  int tests = 0;
  int fails = 0;
  int strobes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_diag_front uut (
    .clk(clk), .rst(rst), .sclk(sclk), .si(si), .cs_n(cs_n),
    .drv_rst_n(drv_rst_n), .sense(sense), .so_data(so_data),
    .so_oe(so_oe), .par_out(par_out), .load_strobe(load_strobe)
  );

  always @(negedge clk) if (load_strobe) strobes++;

  task automatic chk(input logic ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full transfer of n bits, MSB of din[n-1:0] first
  task automatic xfer(input logic [15:0] din, input int n, input logic [7:0] sv);
    logic [7:0] old_par;
    int         old_cnt;
    logic       exp;
    old_par = par_out;
    old_cnt = strobes;
    sense = sv;
    cs_n = 1'b0;
    wait_n(H);
    chk(so_oe == 1'b1, "R5 oe while selected", 16'(so_oe), 16'h1);
    for (int i = 0; i < n; i++) begin
      si = din[n-1-i];
      sclk = 1'b1;
      wait_n(H);
      exp = (i < 8) ? sv[7-i] : din[n-1-(i-8)];
      if (i < 8) chk(so_data == exp, "R4 R2 diagnostic bit", 16'(so_data), 16'(exp));
      else       chk(so_data == exp, "R8 R3 chained bit", 16'(so_data), 16'(exp));
      sclk = 1'b0;
      wait_n(H);
    end
    cs_n = 1'b1;
    wait_n(2);
    chk(par_out == old_par, "R10 no update on second edge", 16'(par_out), 16'(old_par));
    wait_n(1);
    chk(par_out == din[7:0], "R10 R7 update on third edge", 16'(par_out), 16'(din[7:0]));
    wait_n(H);
    chk(par_out == din[7:0], "R7 R3 latched word", 16'(par_out), 16'(din[7:0]));
    chk(strobes == old_cnt + 1, "R7 one strobe", 16'(strobes), 16'(old_cnt + 1));
    chk(so_oe == 1'b0, "R5 oe off", 16'(so_oe), 16'h0);
    chk(so_data == 1'b0, "R5 so cleared", 16'(so_data), 16'h0);
  endtask

  task automatic t_reset;
    wait_n(4);
    rst = 1'b0;
    wait_n(H);
    chk(par_out == 8'h00, "R1 par after reset", 16'(par_out), 16'h0);
    chk(so_oe == 1'b0, "R1 oe after reset", 16'(so_oe), 16'h0);
    chk(so_data == 1'b0, "R1 so after reset", 16'(so_data), 16'h0);
    chk(strobes == 0, "R1 no strobe", 16'(strobes), 16'h0);
  endtask

  task automatic t_gated;
    logic [7:0] p;
    int         c;
    p = par_out;
    c = strobes;
    for (int k = 0; k < 5; k++) begin
      si = k[0];
      sclk = 1'b1; wait_n(H);
      sclk = 1'b0; wait_n(H);
    end
    chk(par_out == p, "R6 par unchanged", 16'(par_out), 16'(p));
    chk(strobes == c, "R6 no strobe", 16'(strobes), 16'(c));
    chk(so_oe == 1'b0, "R6 oe low", 16'(so_oe), 16'h0);
    chk(so_data == 1'b0, "R6 so unchanged", 16'(so_data), 16'h0);
  endtask

  task automatic t_coincident;
    sense = 8'h80;
    si = 1'b1;
    cs_n = 1'b0;
    sclk = 1'b1;
    wait_n(H);
    chk(so_data == 1'b0, "R9 rise dropped at select", 16'(so_data), 16'h0);
    sclk = 1'b0;
    wait_n(H);
    for (int k = 0; k < 7; k++) begin
      sclk = 1'b1; wait_n(H);
      chk(so_data == sense[6-k], "R9 R4 shifted sense", 16'(so_data), 16'(sense[6-k]));
      sclk = 1'b0; wait_n(H);
    end
    cs_n = 1'b1;
    wait_n(H);
    chk(par_out == 8'hFF, "R9 eight falls only", 16'(par_out), 16'hFF);
  endtask

  task automatic t_clear_pin;
    int c;
    c = strobes;
    drv_rst_n = 1'b0;
    wait_n(H);
    chk(par_out == 8'h00, "R1 clear pin par", 16'(par_out), 16'h0);
    chk(so_oe == 1'b0, "R1 clear pin oe", 16'(so_oe), 16'h0);
    chk(strobes == c, "R1 clear no strobe", 16'(strobes), 16'(c));
    drv_rst_n = 1'b1;
    wait_n(H);
  endtask

  initial begin
    t_reset;
    xfer(16'h005A, 8, 8'hC3);
    xfer(16'h00A5, 8, 8'h0F);
    xfer(16'h3CE1, 16, 8'h96);
    t_gated;
    t_coincident;
    t_clear_pin;
    xfer(16'h0069, 8, 8'h3C);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule